// File: doc/BRIEF.md
# Microprogram Sequencer Jump Unit

This block produces the next micro-address for a horizontally microcoded execution unit. It holds a 13-bit micro-instruction pointer. Each clock it looks at the 32-bit microword that the external microcode store returns for the current pointer. If the microword is not a jump, the pointer moves to the next sequential word. If it is a jump, the block chooses a target from one of several sources and tests a condition against the zero flag of the most recent ALU result.

Jump targets can come from five places:
- the microword's immediate field;
- the fetched instruction code byte, for first-level instruction decode;
- an immediate whose low nibble is replaced by the code byte's low nibble, for addressing-mode tables;
- a single saved return register, for one level of micro-subroutine;
- a 3-bit bit index taken from the byte the bus unit returned, for bit-mask tables.

A jump that is marked as a call also stores the sequential successor address in the return register.

Top module: `mseq_jump_unit`

## Requirements
- R1: A microword whose bits [31:28] are not 4'h1 sets the pointer to its current value plus one on the next clock. The value 8191 wraps to 0.
- R2: A taken jump with bits [27:24] equal to 4'h1 stores the current pointer plus one in the return register. A source-3 jump taken later returns to that value.
- R3: A taken jump with source field bits [22:20] = 0 loads the pointer from microword bits [12:0].
- R4: A taken jump with source 1 loads the pointer with {5'b0, codeByte}.
- R5: A taken jump with source 2 loads the pointer with {microword[8:0], codeByte[3:0]}.
- R6: A taken jump with source 3 loads the pointer with the return register value as it stood before that clock edge.
- R7: A taken jump with source 4 loads the pointer with {10'b0, busData[2:0]}.
- R8: The condition field bits [19:16] controls whether a jump is taken. Code 0 always takes the jump. Code 1 takes it only when aluZero is 0. Code 2 takes it only when aluZero is 1.
- R9: Condition codes 3 to 15 and source codes 5 to 7 give no jump, and the pointer increments. A jump that is not taken, call or not, leaves the return register unchanged. This is observable through a later source-3 jump.
- R10: With rstN low at a clock edge, the pointer and the return register both become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| microWord | input | 32 | Microword at the current pointer |
| codeByte | input | 8 | Current instruction code byte |
| busData | input | 8 | Byte returned by the bus unit |
| aluZero | input | 1 | Last ALU result was zero |
| microAddr | output | 13 | Micro-instruction pointer (the address to fetch) |

## Verification
A call and a return can happen in the same cycle. A microword marked as a call can also use source 3. It must then jump to the return address saved earlier and, in the same edge, replace that register with its own successor. The bench provokes this with a directed sequence: a call, a call-return, and then a plain return. The first return must land on the older saved address, and the plain return must land on the address saved by the call-return. Random microwords also hit this case repeatedly, and every cycle is compared with a bench model that updates the pointer and the return register from values taken before the edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W  = 32;
  localparam logic [3:0] CLASS_JUMP = 4'h1;
  localparam logic [3:0] MARK_CALL  = 4'h1;

  typedef enum logic [2:0] {
    SRC_IMM    = 3'd0,
    SRC_OPC    = 3'd1,
    SRC_SPLICE = 3'd2,
    SRC_RET    = 3'd3,
    SRC_BIT    = 3'd4
  } srcSel_e;

  typedef struct packed {
    logic    take;
    logic    saveRet;
    srcSel_e src;
  } seqCtl_t;
endpackage

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic [WORD_W-1:0] microWord,
  input  logic              aluZero,
  output seqCtl_t           ctl
);
  logic [3:0] opClass, callMark, condCode;
  logic [2:0] srcCode;
  logic       isJump, condOk, srcOk;

  assign opClass  = microWord[31:28];
  assign callMark = microWord[27:24];
  assign srcCode  = microWord[22:20];
  assign condCode = microWord[19:16];

  assign isJump = (opClass == CLASS_JUMP);
  assign srcOk  = (srcCode <= 3'd4);

  always_comb begin
    unique case (condCode)
      4'd0:    condOk = 1'b1;
      4'd1:    condOk = !aluZero;
      4'd2:    condOk = aluZero;
      default: condOk = 1'b0;
    endcase
  end

  always_comb begin
    ctl.take    = isJump && condOk && srcOk;
    ctl.saveRet = ctl.take && (callMark == MARK_CALL);
    ctl.src     = srcOk ? srcSel_e'(srcCode) : SRC_IMM;
  end
endmodule

// File: rtl/mseq_path.sv
module mseq_path
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] imm,
  input  logic [7:0]        codeByte,
  input  logic [7:0]        busData,
  output logic [ADDR_W-1:0] ptr
);
  localparam int OPC_PAD = ADDR_W - 8;
  localparam int BIT_PAD = ADDR_W - 3;

  logic [ADDR_W-1:0] retReg, seqNext, target;

  assign seqNext = ptr + 1'b1;

  always_comb begin
    unique case (ctl.src)
      SRC_OPC:    target = {{OPC_PAD{1'b0}}, codeByte};
      SRC_SPLICE: target = {imm[ADDR_W-5:0], codeByte[3:0]};
      SRC_RET:    target = retReg;
      SRC_BIT:    target = {{BIT_PAD{1'b0}}, busData[2:0]};
      default:    target = imm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      retReg <= '0;
    end else begin
      ptr <= ctl.take ? target : seqNext;
      if (ctl.saveRet) retReg <= seqNext;
    end
  end

  p_reset_r10: assert property (@(posedge clk) !rstN |=> (ptr == '0 && retReg == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.take |=> ptr == $past(ptr) + 1'b1);
  p_call_save_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.saveRet |=> retReg == $past(ptr) + 1'b1);
  p_ret_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.saveRet |=> $stable(retReg));
  p_return_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.src == SRC_RET) |=> ptr == $past(retReg));
  p_opc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.src == SRC_OPC) |=> ptr == ADDR_W'($past(codeByte)));
  p_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.src == SRC_BIT) |=> ptr == ADDR_W'($past(busData[2:0])));
  p_imm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.src == SRC_IMM) |=> ptr == $past(imm));
endmodule

// File: rtl/mseq_jump_unit.sv
module mseq_jump_unit
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       microWord,
  input  logic [7:0]        codeByte,
  input  logic [7:0]        busData,
  input  logic              aluZero,
  output logic [ADDR_W-1:0] microAddr
);
  seqCtl_t ctl;

  mseq_ctrl u_ctrl (
    .microWord (microWord),
    .aluZero   (aluZero),
    .ctl       (ctl)
  );

  mseq_path #(.ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .imm      (microWord[ADDR_W-1:0]),
    .codeByte (codeByte),
    .busData  (busData),
    .ptr      (microAddr)
  );

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (microWord[31:28] == 4'h1 && (microWord[19:16] > 4'd2 || microWord[22:20] > 3'd4))
    |=> microAddr == $past(microAddr) + 1'b1);
  p_cond_r8: assert property (@(posedge clk) disable iff (!rstN)
    (microWord[31:28] == 4'h1 && microWord[22:20] == 3'd0 &&
     ((microWord[19:16] == 4'd1 && !aluZero) || (microWord[19:16] == 4'd2 && aluZero)))
    |=> microAddr == $past(microWord[ADDR_W-1:0]));
endmodule

// File: tb/sim_mseq_jump_unit.sv
module sim_mseq_jump_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] microWord = '0;
  logic [7:0]  codeByte = '0, busData = '0;
  logic        aluZero = 1'b0;
  logic [12:0] microAddr;

  int checks = 0, fails = 0;
  logic [12:0] mPtr = '0, mRet = '0;

  always #10 clk = ~clk;

  mseq_jump_unit u0 (.clk(clk), .rstN(rstN), .microWord(microWord), .codeByte(codeByte),
                     .busData(busData), .aluZero(aluZero), .microAddr(microAddr));

  function automatic logic taken(input logic [31:0] mw, input logic z);
    logic ok;
    case (mw[19:16])
      4'd0: ok = 1'b1;
      4'd1: ok = !z;
      4'd2: ok = z;
      default: ok = 1'b0;
    endcase
    return mw[31:28] == 4'h1 && ok && mw[22:20] <= 3'd4;
  endfunction

  function automatic logic [12:0] expNext(input logic [31:0] mw, input logic [7:0] cb,
      input logic [7:0] bd, input logic z, input logic [12:0] p, input logic [12:0] r);
    if (!taken(mw, z)) return p + 13'd1;
    case (mw[22:20])
      3'd0: return mw[12:0];
      3'd1: return {5'b0, cb};
      3'd2: return {mw[8:0], cb[3:0]};
      3'd3: return r;
      default: return {10'b0, bd[2:0]};
    endcase
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] cls, input logic [3:0] call,
      input logic [2:0] src, input logic [3:0] cond, input logic [12:0] imm);
    return {cls, call, 1'b0, src, cond, 3'b0, imm};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [31:0] mw, input logic [7:0] cb,
                      input logic [7:0] bd, input logic z);
    logic [12:0] e;
    microWord = mw; codeByte = cb; busData = bd; aluZero = z;
    e = expNext(mw, cb, bd, z, mPtr, mRet);
    if (taken(mw, z) && mw[27:24] == 4'h1) mRet = mPtr + 13'd1;
    mPtr = e;
    @(posedge clk); @(negedge clk);
    check(req, microAddr, e);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    microWord = mkWord(4'h1, 4'h0, 3'd0, 4'd0, 13'h0ABC);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", microAddr, 13'd0);
    rstN = 1'b1;
    step("R1", mkWord(4'h3, 4'h1, 3'd0, 4'd0, 13'h1234), 8'h00, 8'h00, 1'b0);
    step("R3", mkWord(4'h1, 4'h0, 3'd0, 4'd0, 13'h1FFF), 8'h00, 8'h00, 1'b0);
    step("R1", mkWord(4'h0, 4'h0, 3'd0, 4'd0, 13'h0000), 8'h00, 8'h00, 1'b0);
    step("R4", mkWord(4'h1, 4'h0, 3'd1, 4'd0, 13'h0000), 8'hC7, 8'h00, 1'b0);
    step("R5", mkWord(4'h1, 4'h0, 3'd2, 4'd0, 13'h01A5), 8'hF3, 8'h00, 1'b0);
    step("R7", mkWord(4'h1, 4'h0, 3'd4, 4'd0, 13'h0FFF), 8'h00, 8'hFE, 1'b0);
    step("R8", mkWord(4'h1, 4'h0, 3'd0, 4'd1, 13'h0100), 8'h00, 8'h00, 1'b1);
    step("R8", mkWord(4'h1, 4'h0, 3'd0, 4'd1, 13'h0200), 8'h00, 8'h00, 1'b0);
    step("R8", mkWord(4'h1, 4'h0, 3'd0, 4'd2, 13'h0300), 8'h00, 8'h00, 1'b0);
    step("R8", mkWord(4'h1, 4'h0, 3'd0, 4'd2, 13'h0400), 8'h00, 8'h00, 1'b1);
    step("R2", mkWord(4'h1, 4'h1, 3'd0, 4'd0, 13'h0800), 8'h00, 8'h00, 1'b0);
    step("R9", mkWord(4'h1, 4'h1, 3'd0, 4'd2, 13'h0900), 8'h00, 8'h00, 1'b0);
    step("R9", mkWord(4'h1, 4'h0, 3'd6, 4'd0, 13'h0900), 8'h00, 8'h00, 1'b0);
    step("R9", mkWord(4'h1, 4'h0, 3'd0, 4'd7, 13'h0900), 8'h00, 8'h00, 1'b0);
    step("R6", mkWord(4'h1, 4'h0, 3'd3, 4'd0, 13'h0000), 8'h00, 8'h00, 1'b0);
    step("R2", mkWord(4'h1, 4'h1, 3'd0, 4'd0, 13'h0A00), 8'h00, 8'h00, 1'b0);
    step("R6", mkWord(4'h1, 4'h1, 3'd3, 4'd0, 13'h0000), 8'h00, 8'h00, 1'b0);
    step("R6", mkWord(4'h1, 4'h0, 3'd3, 4'd0, 13'h0000), 8'h00, 8'h00, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] cls, call, cond;
      logic [2:0] src;
      cls  = ($urandom % 4 != 0) ? 4'h1 : 4'($urandom);
      call = ($urandom % 2 == 0) ? 4'h1 : 4'($urandom);
      src  = 3'($urandom);
      cond = ($urandom % 4 != 0) ? 4'($urandom % 3) : 4'($urandom);
      step("R1-random", mkWord(cls, call, src, cond, 13'($urandom)),
           8'($urandom), 8'($urandom), 1'($urandom));
    end
    rstN = 1'b0;
    mPtr = '0; mRet = '0;
    @(posedge clk); @(negedge clk);
    check("R10", microAddr, 13'd0);
    rstN = 1'b1;
    step("R10", mkWord(4'h1, 4'h0, 3'd3, 4'd0, 13'h0123), 8'h00, 8'h00, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule